// File: doc/BRIEF.md
# Display RAM Address Pointer

This block keeps the page and column address used by a host to reach a byte-wide display memory of five pages with 120 columns each. Commands from a decoder load the page or the column, save the column into a one-entry shadow, restore it from the shadow, or arm a bulk clear. Host data strobes produce a RAM access at the current address. The column then steps forward by one and returns to column 0 after column 119.

A bulk clear does not start when it is commanded. It is armed, and the next host data write starts it as a dummy write. That write stores nothing and does not move the column pointer. The clear then writes zero to one byte per clock, walking page by page and column by column, and raises `busy_o` while it runs. Host reads and writes are dropped while `busy_o` is high. Pointer commands are still accepted during a clear.

There are two kinds of clear. The graphic clear wipes pages 0 to 3. The icon clear wipes page 4 only, and it is armed only if the page pointer is already 4. If both are armed, one dummy write wipes pages 0 to 4 in a single pass.

Top module: `disp_addr_ptr`

## Requirements
- R1: During and after reset, the page is 0, the column is 0, the shadow column is 0, no clear is armed, `busy_o` is 0 and neither `ram_we_o` nor `ram_re_o` is asserted.
- R2: Outside a clear, with no clear armed, `data_wr_i` asserts `ram_we_o` in the same cycle. The address is the current page and column, and `ram_wdata_o` equals `wr_data_i`. The column then advances by one.
- R3: Outside a clear, `data_rd_i` asserts `ram_re_o` at the current address in the same cycle, and the column then advances by one.
- R4: When an access advances the column from 119, the column becomes 0 and the page is unchanged.
- R5: A column load takes the 7-bit value. Any value above 119 is stored as 119.
- R6: A page load takes the 3-bit value. Any value above 4 is stored as 4.
- R7: A save copies the column held before the cycle's access into the shadow. A restore copies the shadow into the column.
- R8: After a graphic clear is armed, the next host data write writes nothing and leaves the column unchanged. From the following cycle, `busy_o` is high for 480 cycles. In each of those cycles `ram_we_o` is high and `ram_wdata_o` is 0, and the address runs from page 0 column 0 up to page 3 column 119, column fastest.
- R9: An icon clear command is armed only when the page pointer is 4, and is ignored otherwise. Its dummy write starts 120 zero-writes to page 4. If both clears are armed, one run covers pages 0 to 4 (600 cycles).
- R10: While `busy_o` is high, host reads and writes start no access and do not move the column. Clear commands are ignored.
- R11: When a column load or a restore falls in the same cycle as a host access, the access uses the old address, and the load or restore sets the final column.
- R12: A host read while a clear is armed is a normal read. It neither starts nor cancels the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_page_ld_i | input | 1 | Load page pointer |
| cmd_page_i | input | 3 | Page value |
| cmd_col_ld_i | input | 1 | Load column pointer |
| cmd_col_i | input | 7 | Column value |
| cmd_save_i | input | 1 | Copy column to shadow |
| cmd_restore_i | input | 1 | Copy shadow to column |
| cmd_clr_main_i | input | 1 | Arm clear of pages 0 to 3 |
| cmd_clr_icon_i | input | 1 | Arm clear of page 4 |
| data_wr_i | input | 1 | Host data write strobe |
| data_rd_i | input | 1 | Host data read strobe |
| wr_data_i | input | 8 | Host write byte |
| ram_page_o | output | 3 | RAM page address |
| ram_col_o | output | 7 | RAM column address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_re_o | output | 1 | RAM read enable |
| busy_o | output | 1 | Bulk clear in progress |

## Verification
The bench puts two functions in one cycle in two ways. First, a column load or a restore is issued together with a host write or read, and the bench checks that the access goes to the old address while the command sets the next column. Second, host strobes are driven while a clear is armed and while it runs. The dummy write must store nothing and leave the column where it was, reads must pass through normally, and strobes during `busy_o` must not reach the RAM. A behavioural reference model steps once per clock and is compared with every output on every cycle.

// File: rtl/dap_pkg.sv
package dap_pkg;
  typedef enum logic {CLR_IDLE, CLR_RUN} clr_state_e;

  // Saturate a loaded value at the last legal index.
  function automatic int unsigned sat_idx(int unsigned v, int unsigned last);
    return (v > last) ? last : v;
  endfunction
endpackage

// File: rtl/dap_col_ptr.sv
module dap_col_ptr #(
  parameter int NUM_COLS = 120,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ld_i,
  input  logic [COL_W-1:0] ld_val_i,
  input  logic             save_i,
  input  logic             restore_i,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  logic [COL_W-1:0] col_q, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (ld_i)           col_q <= COL_W'(dap_pkg::sat_idx(int'(ld_val_i), NUM_COLS - 1));
      else if (restore_i) col_q <= shadow_q;
      else if (adv_i)     col_q <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
      if (save_i) shadow_q <= col_q;
    end
  end

  assign col_o = col_q;

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ld_i && !restore_i && col_q == LAST_COL |=> col_q == '0);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ld_i && !restore_i && col_q != LAST_COL |=> col_q == $past(col_q) + COL_W'(1));
  a_r5_range: assert property (@(posedge clk_i) disable iff (!rst_ni) col_q <= LAST_COL);
  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !ld_i && !save_i |=> col_q == shadow_q);
endmodule

// File: rtl/dap_page_ptr.sv
module dap_page_ptr #(
  parameter int NUM_PAGES = 5,
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] ld_val_i,
  output logic [PAGE_W-1:0] page_o
);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (ld_i) page_q <= PAGE_W'(dap_pkg::sat_idx(int'(ld_val_i), NUM_PAGES - 1));
  end

  assign page_o = page_q;

  a_r6_range: assert property (@(posedge clk_i) disable iff (!rst_ni) page_q <= LAST_PAGE);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni) !ld_i |=> $stable(page_q));
endmodule

// File: rtl/dap_clear_seq.sv
module dap_clear_seq #(
  parameter int NUM_PAGES = 5,
  parameter int NUM_COLS  = 120,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] first_page_i,
  input  logic [PAGE_W-1:0] last_page_i,
  output logic              busy_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o
);
  import dap_pkg::*;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  clr_state_e        state_q;
  logic [PAGE_W-1:0] page_q, last_q;
  logic [COL_W-1:0]  col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CLR_IDLE;
      page_q  <= '0;
      last_q  <= '0;
      col_q   <= '0;
    end else if (state_q == CLR_IDLE) begin
      if (start_i) begin
        state_q <= CLR_RUN;
        page_q  <= first_page_i;
        last_q  <= last_page_i;
        col_q   <= '0;
      end
    end else if (col_q == LAST_COL) begin
      col_q <= '0;
      if (page_q == last_q) state_q <= CLR_IDLE;
      else                  page_q  <= page_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign busy_o = (state_q == CLR_RUN);
  assign page_o = page_q;
  assign col_o  = col_q;

  a_r8_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && col_q != LAST_COL |=> busy_o && col_q == $past(col_q) + COL_W'(1) && $stable(page_q));
  a_r8_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && col_q == '0);
endmodule

// File: rtl/disp_addr_ptr.sv
module disp_addr_ptr #(
  parameter int NUM_PAGES = 5,
  parameter int NUM_COLS  = 120,
  parameter int DATA_W    = 8,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_page_ld_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic              cmd_col_ld_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic              cmd_save_i,
  input  logic              cmd_restore_i,
  input  logic              cmd_clr_main_i,
  input  logic              cmd_clr_icon_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PAGE_W-1:0] ram_page_o,
  output logic [COL_W-1:0]  ram_col_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_re_o,
  output logic              busy_o
);
  localparam logic [PAGE_W-1:0] ICON_PAGE = PAGE_W'(NUM_PAGES - 1);
  localparam logic [PAGE_W-1:0] MAIN_LAST = PAGE_W'(NUM_PAGES - 2);

  logic              pend_main_q, pend_icon_q, pending;
  logic              busy, dummy_wr, host_wr, host_rd;
  logic [PAGE_W-1:0] ptr_page, clr_page;
  logic [COL_W-1:0]  ptr_col, clr_col;

  assign pending  = pend_main_q | pend_icon_q;
  assign dummy_wr = !busy && data_wr_i && pending;
  assign host_wr  = !busy && data_wr_i && !pending;
  assign host_rd  = !busy && data_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_main_q <= 1'b0;
      pend_icon_q <= 1'b0;
    end else if (dummy_wr) begin
      pend_main_q <= 1'b0;
      pend_icon_q <= 1'b0;
    end else if (!busy) begin
      if (cmd_clr_main_i) pend_main_q <= 1'b1;
      if (cmd_clr_icon_i && ptr_page == ICON_PAGE) pend_icon_q <= 1'b1;
    end
  end

  dap_page_ptr #(.NUM_PAGES(NUM_PAGES)) u_page (
    .clk_i, .rst_ni, .ld_i(cmd_page_ld_i), .ld_val_i(cmd_page_i), .page_o(ptr_page));

  dap_col_ptr #(.NUM_COLS(NUM_COLS)) u_col (
    .clk_i, .rst_ni, .adv_i(host_wr | host_rd), .ld_i(cmd_col_ld_i), .ld_val_i(cmd_col_i),
    .save_i(cmd_save_i), .restore_i(cmd_restore_i), .col_o(ptr_col));

  dap_clear_seq #(.NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS)) u_clr (
    .clk_i, .rst_ni, .start_i(dummy_wr),
    .first_page_i(pend_main_q ? '0 : ICON_PAGE),
    .last_page_i(pend_icon_q ? ICON_PAGE : MAIN_LAST),
    .busy_o(busy), .page_o(clr_page), .col_o(clr_col));

  assign ram_page_o  = busy ? clr_page : ptr_page;
  assign ram_col_o   = busy ? clr_col  : ptr_col;
  assign ram_we_o    = busy | host_wr;
  assign ram_wdata_o = (!busy && host_wr) ? wr_data_i : '0;
  assign ram_re_o    = host_rd;
  assign busy_o      = busy;

  a_r8_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_wr && !cmd_col_ld_i && !cmd_restore_i |=> busy_o && $stable(ptr_col));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !cmd_col_ld_i && !cmd_restore_i |=> $stable(ptr_col));
  a_r9_icon_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_icon_q && ptr_page != ICON_PAGE |=> !pend_icon_q);
  a_r12_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && pending && !data_wr_i |=> !busy && pending);
endmodule

// File: tb/tb_disp_addr_ptr.sv
module tb_disp_addr_ptr;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pg_ld = 0, col_ld = 0, save = 0, restore = 0, clr_main = 0, clr_icon = 0;
  logic       wr = 0, rd = 0;
  logic [2:0] pval = 0;
  logic [6:0] cval = 0;
  logic [7:0] wdata = 0;
  logic [2:0] o_page;
  logic [6:0] o_col;
  logic       o_we, o_re, o_busy;
  logic [7:0] o_wd;

  int    n_tests = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  disp_addr_ptr dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_page_ld_i(pg_ld), .cmd_page_i(pval),
    .cmd_col_ld_i(col_ld), .cmd_col_i(cval), .cmd_save_i(save), .cmd_restore_i(restore),
    .cmd_clr_main_i(clr_main), .cmd_clr_icon_i(clr_icon), .data_wr_i(wr), .data_rd_i(rd),
    .wr_data_i(wdata), .ram_page_o(o_page), .ram_col_o(o_col), .ram_we_o(o_we),
    .ram_wdata_o(o_wd), .ram_re_o(o_re), .busy_o(o_busy));

  // Behavioural reference model
  int m_page, m_col, m_shadow, m_cp, m_cc, m_endp, o_c, o_p;
  bit m_pm, m_pi, m_busy, o_b, dmy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_page = 0; m_col = 0; m_shadow = 0; m_cp = 0; m_cc = 0; m_endp = 0;
      m_pm = 0; m_pi = 0; m_busy = 0;
    end else begin
      o_c = m_col; o_p = m_page; o_b = m_busy;
      dmy = !o_b && wr && (m_pm || m_pi);
      if (o_b) begin
        if (m_cc == 119) begin
          m_cc = 0;
          if (m_cp == m_endp) m_busy = 0; else m_cp++;
        end else m_cc++;
      end else if (dmy) begin
        m_busy = 1; m_cp = m_pm ? 0 : 4; m_endp = m_pi ? 4 : 3; m_cc = 0; m_pm = 0; m_pi = 0;
      end else if (wr || rd) m_col = (o_c == 119) ? 0 : o_c + 1;
      if (col_ld) m_col = (cval > 119) ? 119 : int'(cval);
      else if (restore) m_col = m_shadow;
      if (save) m_shadow = o_c;
      if (pg_ld) m_page = (pval > 4) ? 4 : int'(pval);
      if (!o_b && !dmy) begin
        if (clr_main) m_pm = 1;
        if (clr_icon && o_p == 4) m_pi = 1;
      end
    end
  end

  task automatic compare();
    int  ep, ec, ewd;
    bit  ewe, ere, eb;
    if (m_busy) begin
      ep = m_cp; ec = m_cc; ewe = 1; ewd = 0; ere = 0; eb = 1;
    end else begin
      ep = m_page; ec = m_col; ewe = wr && !(m_pm || m_pi);
      ewd = ewe ? int'(wdata) : 0; ere = rd; eb = 0;
    end
    n_tests++;
    if (o_page !== 3'(ep) || o_col !== 7'(ec) || o_we !== ewe || o_wd !== 8'(ewd) ||
        o_re !== ere || o_busy !== eb) begin
      n_fail++;
      $display("FAIL %s t=%0t act page=%0d col=%0d we=%b wd=%h re=%b busy=%b exp page=%0d col=%0d we=%b wd=%h re=%b busy=%b",
               tag, $time, o_page, o_col, o_we, o_wd, o_re, o_busy, ep, ec, ewe, ewd[7:0], ere, eb);
    end
  endtask

  task automatic step();
    #1 compare();
    @(negedge clk);
    {pg_ld, col_ld, save, restore, clr_main, clr_icon, wr, rd} = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; idle(3);
    rst_n = 1; idle(2);

    tag = "R2"; for (int i = 0; i < 3; i++) begin wr = 1; wdata = 8'(8'hA0 + i); step(); end
    tag = "R3"; rd = 1; step(); rd = 1; step(); idle(1);

    tag = "R4"; col_ld = 1; cval = 117; step();
    for (int i = 0; i < 4; i++) begin wr = 1; wdata = 8'(i); step(); end
    rd = 1; step(); idle(1);

    tag = "R5"; col_ld = 1; cval = 127; step(); idle(1);
    col_ld = 1; cval = 120; step(); col_ld = 1; cval = 119; step(); idle(1);

    tag = "R6"; pg_ld = 1; pval = 2; step(); pg_ld = 1; pval = 7; step(); idle(1);
    pg_ld = 1; pval = 5; step(); pg_ld = 1; pval = 1; step(); idle(1);

    tag = "R7"; col_ld = 1; cval = 5; step(); save = 1; step();
    col_ld = 1; cval = 50; step(); restore = 1; step(); idle(1);
    save = 1; rd = 1; step(); idle(1); restore = 1; step(); idle(1);

    tag = "R11"; col_ld = 1; cval = 30; wr = 1; wdata = 8'h5A; step(); idle(1);
    restore = 1; rd = 1; step(); idle(1);
    col_ld = 1; cval = 119; rd = 1; step(); idle(1);

    tag = "R12"; clr_main = 1; step(); rd = 1; step(); rd = 1; step(); idle(1);
    tag = "R8"; wr = 1; wdata = 8'hFF; step();
    for (int i = 0; i < 40; i++) begin tag = "R10"; wr = i[0]; rd = ~i[0]; wdata = 8'h33; step(); end
    tag = "R10"; clr_icon = 1; clr_main = 1; step();
    tag = "R8"; idle(460); wr = 1; wdata = 8'h11; step(); idle(1);

    tag = "R9"; pg_ld = 1; pval = 2; step(); clr_icon = 1; step();
    wr = 1; wdata = 8'h22; step(); idle(1);
    pg_ld = 1; pval = 4; step(); clr_icon = 1; step(); wr = 1; step(); idle(125);
    clr_main = 1; step(); clr_icon = 1; step(); wr = 1; step(); idle(605);
    wr = 1; wdata = 8'h44; step(); rd = 1; step(); idle(2);
    done = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (done || cyc > 150000) begin
      if (!done) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog act=hung exp=finished");
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule